// File: doc/BRIEF.md
# Two-Wire Target with Auto-Incrementing Register Bank

This block is a two-wire (I2C) bus target. It lets a bus controller read and write a small bank of byte-wide registers kept inside the block. The clock and data lines come in as plain inputs. The block's only drive onto the bus is a pull-low control for the data line, so it can hold the line low or let it float, and external pull-ups set the high level. Both lines are brought into the system clock domain through two-flop synchronisers. Rising and falling clock edges, start conditions (data falls while clock is high) and stop conditions (data rises while clock is high) are all found from the synchronised copies.

A write transaction carries a fixed 7-bit device address with a direction bit of 0. The next byte loads the register pointer. Every byte after that is stored at the pointer, and the pointer then steps forward, wrapping from the last register back to register 0. A read transaction (direction bit 1) returns the register at the current pointer and advances the pointer once per byte. It keeps returning bytes for as long as the controller acknowledges them. A common use is to write the pointer, issue a repeated start, and then read from that pointer. All register contents are also available on a flat parallel output.

The controller in `tw_regport` has these states. IDLE waits for a start. ADDR gathers the address byte and goes to ADDR_ACK on a match, or to IGNORE on a mismatch. ADDR_ACK goes to PTR for a write or to RDATA for a read. PTR goes to PTR_ACK, and PTR_ACK goes to WDATA. WDATA goes to WDATA_ACK, and WDATA_ACK goes back to WDATA. RDATA goes to RDATA_ACK. RDATA_ACK goes back to RDATA when the controller acknowledges, or to IGNORE when it does not. Every step happens on the clock fall that ends a byte or an acknowledge slot. A stop sends any state to IDLE, and a start or repeated start sends any state to ADDR.

Top module: `tw_regport`

## Requirements
- R1: After reset, `sda_pull` is 0 and every register in the bank reads 0.
- R2: When an address byte equal to `DEV_ADDR` arrives, the block pulls SDA low during the ninth clock pulse. When the address differs, SDA stays released for that pulse, and all following bytes are neither acknowledged nor stored until the next start or stop.
- R3: In a write, the first byte after the address is acknowledged, and its low 3 bits become the register pointer.
- R4: Each data byte after the pointer byte is acknowledged and stored at the pointer, and then the pointer increments. The pointer wraps from register 7 to register 0, so any number of bytes can be written in one transaction.
- R5: In a read, bytes are driven MSB first, starting with the register at the pointer. The pointer advances by one after each byte, with the same wrap from 7 to 0. A new byte follows each acknowledge from the controller (SDA low in the ninth clock).
- R6: When the controller does not acknowledge (SDA high in the ninth clock), the block releases SDA and drives nothing more until a start or stop. The pointer keeps its incremented value, so the next read starts at the following register.
- R7: A start or stop that arrives partway through a byte abandons that byte. Nothing is stored, and a stop returns the block to IDLE.
- R8: A repeated start after the pointer byte begins a new address phase, and a read can then return data from the pointer just written.
- R9: `sda_pull` changes only while the synchronised SCL is low, and it is held at 0 while the block is in IDLE or IGNORE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |
| bank_flat | output | NREG*DW | All registers; register i sits at bits [i*DW +: DW] |

## Verification
The assertions assume a bus controller that follows the protocol. SDA changes only while SCL is low, except for start and stop conditions. Every SCL phase lasts longer than the synchroniser delay. No start or stop is issued while the target is pulling SDA low. The bench master enforces this by driving every line change on a falling system clock, eight cycles apart. It moves SDA only in the middle of an SCL-low phase, and it places starts and stops only after the target has let go of the line. Random transactions pick pointers, lengths, data and the direction mix. Directed cases cover pointer wrap, a wrong address, a NACK that ends a read, and a byte cut short by a stop.

// File: rtl/tw_regport_pkg.sv
package tw_regport_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } tgt_state_t;
endpackage

// File: rtl/tw_line_watch.sv
module tw_line_watch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [SYNC_STAGES-1:0] scl_q, sda_q;
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[SYNC_STAGES-2:0], scl_in};
            sda_q <= {sda_q[SYNC_STAGES-2:0], sda_in};
            scl_p <= scl_q[SYNC_STAGES-1];
            sda_p <= sda_q[SYNC_STAGES-1];
        end
    end

    assign scl_s    = scl_q[SYNC_STAGES-1];
    assign sda_s    = sda_q[SYNC_STAGES-1];
    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

    // R7
    ev_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_ev, stop_ev, scl_rise, scl_fall}));
endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank #(
    parameter int NREG = 8,
    parameter int DW   = 8,
    localparam int PW  = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [PW-1:0]      waddr,
    input  logic [DW-1:0]      wdata,
    input  logic [PW-1:0]      raddr,
    output logic [DW-1:0]      rdata,
    output logic [NREG*DW-1:0] flat
);
    logic [DW-1:0] mem [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign flat[g*DW +: DW] = mem[g];
    end
endmodule

// File: rtl/tw_regport.sv
module tw_regport
    import tw_regport_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2A,
    parameter int NREG = 8,
    parameter int DW   = 8,
    localparam int PW  = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_pull,
    output logic [NREG*DW-1:0] bank_flat
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    tgt_state_t st, nxt;
    logic [7:0]    shreg;
    logic [DW-1:0] obuf, rdata;
    logic [2:0]    bitcnt;
    logic          byte_done, rw_bit, mack;
    logic [PW-1:0] ptr, ptr_inc;
    logic          addr_hit, wr_en, bus_ev;

    tw_line_watch #(.SYNC_STAGES(2)) u_watch (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    assign bus_ev   = start_ev | stop_ev;
    assign addr_hit = (shreg[7:1] == DEV_ADDR);
    assign ptr_inc  = (ptr == PW'(NREG-1)) ? '0 : ptr + 1'b1;
    assign wr_en    = (st == ST_WDATA) && scl_fall && byte_done && !bus_ev;

    tw_reg_bank #(.NREG(NREG), .DW(DW)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(ptr), .wdata(shreg[DW-1:0]),
        .raddr(ptr), .rdata(rdata), .flat(bank_flat)
    );

    always_comb begin
        nxt = st;
        if (stop_ev) nxt = ST_IDLE;
        else if (start_ev) nxt = ST_ADDR;
        else begin
            unique case (st)
                ST_IDLE, ST_IGNORE: nxt = st;
                ST_ADDR:      if (scl_fall && byte_done) nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall) nxt = rw_bit ? ST_RDATA : ST_PTR;
                ST_PTR:       if (scl_fall && byte_done) nxt = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_fall) nxt = ST_WDATA;
                ST_WDATA:     if (scl_fall && byte_done) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) nxt = ST_WDATA;
                ST_RDATA:     if (scl_fall && byte_done) nxt = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall) nxt = mack ? ST_RDATA : ST_IGNORE;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull  <= 1'b0;
            shreg     <= '0;
            obuf      <= '0;
            bitcnt    <= '0;
            byte_done <= 1'b0;
            rw_bit    <= 1'b0;
            mack      <= 1'b0;
            ptr       <= '0;
        end else if (bus_ev) begin
            sda_pull  <= 1'b0;
            bitcnt    <= '0;
            byte_done <= 1'b0;
        end else if (scl_rise) begin
            case (st)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    shreg     <= {shreg[6:0], sda_s};
                    bitcnt    <= bitcnt + 1'b1;
                    byte_done <= (bitcnt == 3'd7);
                end
                ST_RDATA: begin
                    bitcnt    <= bitcnt + 1'b1;
                    byte_done <= (bitcnt == 3'd7);
                end
                ST_RDATA_ACK: mack <= !sda_s;
                default: ;
            endcase
        end else if (scl_fall) begin
            case (st)
                ST_ADDR: if (byte_done) begin
                    rw_bit    <= shreg[0];
                    sda_pull  <= addr_hit;
                    byte_done <= 1'b0;
                end
                ST_ADDR_ACK: begin
                    if (rw_bit) begin
                        obuf     <= rdata;
                        sda_pull <= !rdata[DW-1];
                        bitcnt   <= '0;
                    end else begin
                        sda_pull <= 1'b0;
                    end
                end
                ST_PTR: if (byte_done) begin
                    ptr       <= shreg[PW-1:0];
                    sda_pull  <= 1'b1;
                    byte_done <= 1'b0;
                end
                ST_WDATA: if (byte_done) begin
                    ptr       <= ptr_inc;
                    sda_pull  <= 1'b1;
                    byte_done <= 1'b0;
                end
                ST_PTR_ACK, ST_WDATA_ACK: sda_pull <= 1'b0;
                ST_RDATA: begin
                    if (byte_done) begin
                        sda_pull  <= 1'b0;
                        ptr       <= ptr_inc;
                        byte_done <= 1'b0;
                    end else begin
                        obuf     <= obuf << 1;
                        sda_pull <= !obuf[DW-2];
                    end
                end
                ST_RDATA_ACK: begin
                    if (mack) begin
                        obuf     <= rdata;
                        sda_pull <= !rdata[DW-1];
                        bitcnt   <= '0;
                    end else begin
                        sda_pull <= 1'b0;
                    end
                end
                default: sda_pull <= 1'b0;
            endcase
        end
    end

    // R9
    pull_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !$past(scl_s));
    // R9
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_IGNORE) |-> !sda_pull);
    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr == (($past(ptr) == PW'(NREG-1)) ? '0 : $past(ptr) + 1'b1)));
    // R3
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PTR && scl_fall && byte_done && !bus_ev) |=> (ptr == $past(shreg[PW-1:0])));
    // R7
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (st == ST_IDLE));
endmodule

// File: tb/tw_regport_bench.sv
module tw_regport_bench;
    localparam int Q = 8;
    localparam logic [6:0] ADDR = 7'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_pull;
    logic [63:0] bank_flat;
    logic sda_line;

    assign sda_line = m_sda & ~sda_pull;

    always #2 clk = ~clk;

    tw_regport u_tw_regport (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .sda_pull(sda_pull), .bank_flat(bank_flat)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] model [8];
    logic [2:0] mptr = '0;
    bit done = 0;

    function automatic logic [2:0] step(input logic [2:0] p);
        return (p == 3'd7) ? 3'd0 : p + 3'd1;
    endfunction

    function automatic logic [7:0] reg_of(input logic [63:0] f, input int i);
        return f[i*8 +: 8];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        tick(Q); m_sda = 1'b1;
        tick(Q); scl = 1'b1;
        tick(Q); m_sda = 1'b0;
        tick(Q); scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); m_sda = 1'b0;
        tick(Q); scl = 1'b1;
        tick(Q); m_sda = 1'b1;
        tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            tick(Q); m_sda = v[i];
            tick(Q); scl = 1'b1;
            tick(2*Q); scl = 1'b0;
        end
    endtask

    task automatic wr_byte(input logic [7:0] v, output bit ack);
        send_bits(v, 8);
        tick(Q); m_sda = 1'b1;
        tick(Q); scl = 1'b1;
        tick(Q); ack = !sda_line;
        tick(Q); scl = 1'b0;
    endtask

    task automatic rd_byte(input bit give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            tick(Q); m_sda = 1'b1;
            tick(Q); scl = 1'b1;
            tick(Q); v[i] = sda_line;
            tick(Q); scl = 1'b0;
        end
        tick(Q); m_sda = !give_ack;
        tick(Q); scl = 1'b1;
        tick(2*Q); scl = 1'b0;
        tick(Q); m_sda = 1'b1;
    endtask

    task automatic do_write(input logic [2:0] p, input int n, input logic [7:0] seed_v);
        bit a;
        logic [7:0] d;
        bus_start();
        wr_byte({ADDR, 1'b0}, a); chk(a, "R2 addr ack", a, 1);
        wr_byte({5'd0, p}, a);    chk(a, "R3 ptr ack", a, 1);
        mptr = p;
        for (int k = 0; k < n; k++) begin
            d = seed_v + 8'(k * 37);
            wr_byte(d, a); chk(a, "R4 data ack", a, 1);
            model[mptr] = d;
            mptr = step(mptr);
        end
        bus_stop();
    endtask

    task automatic do_read(input bit set_ptr, input logic [2:0] p, input int n);
        bit a;
        logic [7:0] v;
        bus_start();
        if (set_ptr) begin
            wr_byte({ADDR, 1'b0}, a); chk(a, "R8 addr ack", a, 1);
            wr_byte({5'd0, p}, a);    chk(a, "R8 ptr ack", a, 1);
            mptr = p;
            bus_start();
        end
        wr_byte({ADDR, 1'b1}, a); chk(a, "R2 read addr ack", a, 1);
        for (int k = 0; k < n; k++) begin
            rd_byte(k != n - 1, v);
            chk(v == model[mptr], "R5 read data", v, model[mptr]);
            mptr = step(mptr);
        end
        tick(Q);
        chk(sda_pull == 1'b0, "R6 release after nack", sda_pull, 0);
        bus_stop();
    endtask

    task automatic cmp_bank(input string req);
        for (int i = 0; i < 8; i++)
            chk(reg_of(bank_flat, i) == model[i], req, reg_of(bank_flat, i), model[i]);
    endtask

    initial begin
        bit a;
        logic [7:0] v;
        void'($urandom(32'd20240607));
        for (int i = 0; i < 8; i++) model[i] = '0;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R1
        chk(sda_pull == 1'b0, "R1 pull at reset", sda_pull, 0);
        chk(bank_flat == '0, "R1 bank at reset", 0, 0);

        // R4 wrap across the top of the bank
        do_write(3'd6, 4, 8'hA1);
        cmp_bank("R4 wrap write");

        // R2 wrong address: no ack, later bytes ignored
        bus_start();
        wr_byte({7'h15, 1'b0}, a); chk(!a, "R2 wrong addr nack", a, 0);
        wr_byte(8'h00, a);         chk(!a, "R2 ignored ptr", a, 0);
        wr_byte(8'hFF, a);         chk(!a, "R2 ignored data", a, 0);
        bus_stop();
        cmp_bank("R2 bank unchanged");

        // R8 + R5 wrap on read, R6 pointer retained after nack
        do_read(1'b1, 3'd7, 3);
        do_read(1'b0, 3'd0, 1);

        // R7 partial byte then stop: nothing stored
        bus_start();
        wr_byte({ADDR, 1'b0}, a);
        wr_byte(8'h03, a);
        send_bits(8'h5A, 4);
        bus_stop();
        mptr = 3'd3;
        cmp_bank("R7 abort keeps bank");
        chk(sda_pull == 1'b0, "R7 released after stop", sda_pull, 0);

        // random traffic
        for (int t = 0; t < 14; t++) begin
            logic [2:0] p;
            int n;
            p = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 1) == 0) begin
                n = $urandom_range(1, 10);
                do_write(p, n, 8'($urandom));
            end else begin
                n = $urandom_range(1, 9);
                do_read(1'b1, p, n);
            end
        end
        cmp_bank("R4 final bank");

        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule